// File: doc/BRIEF.md
# Parallel Multi-Window Convolution Array

This block computes a 5x5 Gaussian-weighted average for several horizontally adjacent pixel windows at once. Each clock it may accept one strip of pixels that is five rows tall and `LANES+4` columns wide. From that strip it forms `LANES` overlapping windows, one per lane, and returns one filtered pixel per lane. Together the lanes give `LANES` output pixels per clock. Line buffering, border handling and the packing of results for memory are left to the blocks around it.

The weights are the outer product of the binomial taps 1,4,6,4,1 and sum to 256. The block works on that separable form. Each strip column is reduced once to a vertical weighted sum, and that sum is registered and shared by every lane whose window covers the column, which is at most five lanes. Each lane then combines five neighbouring column sums and rounds the result back to pixel width. All lanes share one pipeline and one valid flag, so every result of a strip appears in the same cycle.

Top module: `conv_lane_array`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0 and every lane of `pix_o` is 0.
- R2: `out_valid_o` is high in the cycle that follows the third rising clock edge after a strip is presented with `in_valid_i` high, and low three edges after a cycle with `in_valid_i` low (latency 3).
- R3: Lane i (bits `[i*PIX_W +: PIX_W]` of `pix_o`) equals `(S + 128) >> 8`. Here S is the sum over r,k in 0..4 of `w[r]*w[k]*p(r, i+k)`, w = {1,4,6,4,1}, and the pixel at row r, column c sits at strip bits `[(r*(LANES+4)+c)*PIX_W +: PIX_W]`.
- R4: Each strip column c reaches exactly the lanes i with i <= c <= i+4, weighted by `w[c-i]`. A change in column c alters no other lane.
- R5: All `LANES` results computed from one strip appear on `pix_o` in the same cycle, under one shared `out_valid_o`.
- R6: A cycle with `in_valid_i` low loads no pipeline stage. When `out_valid_o` is low, `pix_o` keeps the value it last held.
- R7: A strip whose pixels all equal v yields v in every lane. Each column sum of an equal-valued column equals 16 times that value.
- R8: Strips presented on consecutive cycles give results on consecutive cycles, one full set of lanes per clock with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Strip on `strip_i` is valid this cycle |
| strip_i | input | 5*(LANES+4)*PIX_W | Pixel strip, row-major, row 0 in the low bits |
| out_valid_o | output | 1 | All lane results on `pix_o` are new this cycle |
| pix_o | output | LANES*PIX_W | Filtered pixels, lane 0 in the low bits |

## Verification
Two events often fall in the same cycle: a new strip enters the column stage while an idle gap, or an older result, reaches the output register. The bench provokes this by mixing constrained-random valid patterns with gaps, runs of back-to-back strips and single-column impulses across every column position. Every cycle it compares `out_valid_o` and all lanes of `pix_o` with a three-deep scoreboard of reference results built from the formula in R3. After a gap it expects the last result to be held unchanged.

// File: rtl/conv_lane_pkg.sv
`timescale 1ns/1ps
package conv_lane_pkg;
  localparam int TAPS    = 5;
  localparam int GAIN_W  = 4;  // bits of growth from one 1-4-6-4-1 pass (sum 16)
  localparam int NORM_SH = 2 * GAIN_W;
  localparam int LAT     = 3;

  function automatic int unsigned tap_w(input int k);
    case (k)
      0, 4:    return 1;
      1, 3:    return 4;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/col_vsum.sv
`timescale 1ns/1ps
module col_vsum
  import conv_lane_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SUM_W = PIX_W + GAIN_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [TAPS*PIX_W-1:0] col_i,
  output logic [SUM_W-1:0]      sum_o
);
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] sum_q;
  logic             rows_eq;

  always_comb begin
    acc = '0;
    for (int r = 0; r < TAPS; r++)
      acc = acc + SUM_W'(tap_w(r)) * SUM_W'(col_i[r*PIX_W +: PIX_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_q <= '0;
    else if (en_i) sum_q <= acc;
  end

  assign sum_o = sum_q;

  always_comb begin
    rows_eq = 1'b1;
    for (int r = 1; r < TAPS; r++)
      if (col_i[r*PIX_W +: PIX_W] != col_i[PIX_W-1:0]) rows_eq = 1'b0;
  end

  // R7: flat column weighs to 16x its value
  p_col_flat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rows_eq) |=> (sum_o == {$past(col_i[PIX_W-1:0]), {GAIN_W{1'b0}}}));
endmodule

// File: rtl/lane_hsum.sv
`timescale 1ns/1ps
module lane_hsum
  import conv_lane_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int VS_W  = PIX_W + GAIN_W,
  parameter int HS_W  = VS_W + GAIN_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sum_en_i,
  input  logic                 out_en_i,
  input  logic [TAPS*VS_W-1:0] vsum_i,
  output logic [PIX_W-1:0]     pix_o
);
  logic [HS_W-1:0]  acc;
  logic [HS_W-1:0]  hsum_q;
  logic [HS_W-1:0]  rnd;
  logic [PIX_W-1:0] pix_q;
  logic             vs_eq;

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      acc = acc + HS_W'(tap_w(k)) * HS_W'(vsum_i[k*VS_W +: VS_W]);
  end

  // round half up before dropping the weight gain
  assign rnd = hsum_q + HS_W'(1 << (NORM_SH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsum_q <= '0;
      pix_q  <= '0;
    end else begin
      if (sum_en_i) hsum_q <= acc;
      if (out_en_i) pix_q  <= PIX_W'(rnd >> NORM_SH);
    end
  end

  assign pix_o = pix_q;

  always_comb begin
    vs_eq = 1'b1;
    for (int k = 1; k < TAPS; k++)
      if (vsum_i[k*VS_W +: VS_W] != vsum_i[VS_W-1:0]) vs_eq = 1'b0;
  end

  // R7: equal column sums combine to 16x
  p_lane_flat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_en_i && vs_eq) |=> (hsum_q == {$past(vsum_i[VS_W-1:0]), {GAIN_W{1'b0}}}));
endmodule

// File: rtl/conv_lane_array.sv
`timescale 1ns/1ps
module conv_lane_array
  import conv_lane_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PIX_W = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 in_valid_i,
  input  logic [TAPS*(LANES+TAPS-1)*PIX_W-1:0] strip_i,
  output logic                                 out_valid_o,
  output logic [LANES*PIX_W-1:0]               pix_o
);
  localparam int COLS = LANES + TAPS - 1;
  localparam int VS_W = PIX_W + GAIN_W;
  localparam int HS_W = VS_W + GAIN_W;

  logic [LAT-1:0]        v_q;
  logic [TAPS*PIX_W-1:0] col_bus  [COLS];
  logic [VS_W-1:0]       vsum_w   [COLS];
  logic [TAPS*VS_W-1:0]  lane_in  [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else         v_q <= {v_q[LAT-2:0], in_valid_i};
  end
  assign out_valid_o = v_q[LAT-1];

  // one vertical sum per strip column, shared by up to TAPS lanes
  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < TAPS; r++) begin : g_row
      assign col_bus[c][r*PIX_W +: PIX_W] = strip_i[(r*COLS + c)*PIX_W +: PIX_W];
    end
    col_vsum #(.PIX_W(PIX_W), .SUM_W(VS_W)) u_col (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (in_valid_i),
      .col_i  (col_bus[c]),
      .sum_o  (vsum_w[c])
    );
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign lane_in[i][k*VS_W +: VS_W] = vsum_w[i+k];
    end
    lane_hsum #(.PIX_W(PIX_W), .VS_W(VS_W), .HS_W(HS_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sum_en_i (v_q[0]),
      .out_en_i (v_q[1]),
      .vsum_i   (lane_in[i]),
      .pix_o    (pix_o[i*PIX_W +: PIX_W])
    );
  end

  logic [1:0] rst_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rst_cnt_q <= '0;
    else if (rst_cnt_q != 2'd3) rst_cnt_q <= rst_cnt_q + 2'd1;
  end

  // R2: fixed latency of three edges
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_cnt_q == 2'd3) |-> (out_valid_o == $past(in_valid_i, 3)));

  // R6: no new result, no change on the output
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(pix_o));

  // R1: reset values
  always_comb begin
    if (!rst_ni) a_reset_r1: assert (out_valid_o == 1'b0 || $isunknown(out_valid_o));
  end
endmodule

// File: tb/sim_conv_lane_array.sv
`timescale 1ns/1ps
module sim_conv_lane_array;
  localparam int LANES = 4;
  localparam int PIX_W = 8;
  localparam int TAPS  = 5;
  localparam int COLS  = LANES + TAPS - 1;
  localparam int MAXP  = (1 << PIX_W) - 1;

  logic                         clk = 1'b0;
  logic                         rst_ni = 1'b0;
  logic                         in_valid = 1'b0;
  logic [TAPS*COLS*PIX_W-1:0]   strip = '0;
  logic                         out_valid;
  logic [LANES*PIX_W-1:0]       pix;

  int sb [TAPS][COLS];
  int ev [3];
  int ep [3][LANES];
  int hold [LANES];
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  conv_lane_array #(.LANES(LANES), .PIX_W(PIX_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid),
    .strip_i(strip), .out_valid_o(out_valid), .pix_o(pix)
  );

  function automatic int wt(input int k);
    return (k == 0 || k == 4) ? 1 : (k == 2 ? 6 : 4);
  endfunction

  function automatic int ref_lane(input int i);
    int s = 0;
    for (int r = 0; r < TAPS; r++)
      for (int k = 0; k < TAPS; k++)
        s += wt(r) * wt(k) * sb[r][i+k];
    return (s + 128) >>> 8;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int v);
    for (int r = 0; r < TAPS; r++)
      for (int c = 0; c < COLS; c++) sb[r][c] = v;
  endtask

  task automatic fill_rand(input bit extremes);
    for (int r = 0; r < TAPS; r++)
      for (int c = 0; c < COLS; c++)
        sb[r][c] = extremes ? (($urandom % 2) ? MAXP : 0) : int'($urandom % (MAXP + 1));
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input bit v, input string tag);
    int nv [LANES];
    in_valid = v;
    for (int r = 0; r < TAPS; r++)
      for (int c = 0; c < COLS; c++)
        strip[(r*COLS + c)*PIX_W +: PIX_W] = sb[r][c][PIX_W-1:0];
    for (int i = 0; i < LANES; i++) nv[i] = ref_lane(i);
    @(posedge clk);
    ev[2] = ev[1]; ev[1] = ev[0]; ev[0] = v;
    for (int i = 0; i < LANES; i++) begin
      ep[2][i] = ep[1][i]; ep[1][i] = ep[0][i]; ep[0][i] = nv[i];
    end
    @(negedge clk);
    chk("R2 out_valid", int'(out_valid), ev[2]);
    if (ev[2] != 0)
      for (int i = 0; i < LANES; i++) hold[i] = ep[2][i];
    for (int i = 0; i < LANES; i++)
      chk((ev[2] != 0) ? {tag, " lane"} : "R6 hold", int'(pix[i*PIX_W +: PIX_W]), hold[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0c0ffee5));
    for (int i = 0; i < 3; i++) ev[i] = 0;
    for (int i = 0; i < LANES; i++) hold[i] = 0;
    fill(0);
    repeat (3) @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    for (int i = 0; i < LANES; i++) chk("R1 pix", int'(pix[i*PIX_W +: PIX_W]), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R7: flat strips
    fill(100); step(1, "R7");
    fill(MAXP); step(1, "R7");
    fill(0);   step(1, "R7");
    fill(37);  step(1, "R7");
    repeat (3) step(0, "R6");

    // R4: single-column impulse at every position
    for (int c = 0; c < COLS; c++) begin
      fill(0);
      for (int r = 0; r < TAPS; r++) sb[r][c] = MAXP;
      step(1, "R4");
    end
    repeat (3) step(0, "R6");

    // R8: back-to-back stream
    for (int n = 0; n < 24; n++) begin fill_rand(0); step(1, "R8"); end

    // R5: alternating valid with different strips, all lanes compared together
    for (int n = 0; n < 20; n++) begin fill_rand(0); step(n[0], "R5"); end

    // R3/R6: constrained random valid mix, normal and extreme pixels
    for (int n = 0; n < 300; n++) begin
      fill_rand(n % 5 == 0);
      step(($urandom % 10) < 6, "R3");
    end
    repeat (4) step(0, "R6");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule